// File: doc/BRIEF.md
# Programmable Galois Keystream Cipher Channel

This block is one serial cipher channel. A 32-bit Galois-form linear feedback shift register produces one keystream bit per clock, and that bit is XORed with the serial data bit arriving in the same cycle. The feedback polynomial is held in a tap register and the starting state in a state register. Both are written from parallel inputs with a single load strobe, so software or a neighbouring block can choose any polynomial and any seed at run time.

Encryption and decryption are the same operation. A receiver that loads the same taps and seed, and steps in lockstep with the sender, XORs the identical keystream back out of the ciphertext. The channel only advances while its enable is high. While it is disabled the register keeps its position in the sequence, so a paused stream resumes exactly where it stopped.

Top module: `stream_cipher_ch`

## Requirements
- R1: After reset is asserted (active-low, asynchronous), the state and tap registers are zero and data_o is 0.
- R2: A cycle with load_i high copies seed_i into the state register and taps_i into the tap register, whatever en_i is. In that cycle the state does not shift, and data_o is 0 after the edge.
- R3: The keystream bit is bit 0 of the state. On an enabled cycle without load, data_o after the edge equals data_i XOR that bit as it stood before the edge.
- R4: On an enabled cycle without load, the next state is the state shifted right by one place with 0 entering at bit 31. When the bit leaving (old bit 0) is 1, that value is also XORed with the tap mask.
- R5: On a cycle with en_i low and load_i low, the state holds and data_o is 0 after the edge. Stepping continues from the held state when en_i returns high.
- R6: While the state is all zero, the keystream is 0 and stays 0, so an enabled channel passes data_i through unchanged, one cycle late.
- R7: Reloading the same taps and seed and feeding the ciphertext back recovers the original data bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable: step and emit data |
| load_i | input | 1 | Load seed and taps; takes priority over stepping |
| taps_i | input | 32 | Feedback tap mask |
| seed_i | input | 32 | Initial state value |
| data_i | input | 1 | Serial plaintext or ciphertext in |
| data_o | output | 1 | Serial ciphertext or plaintext out |

## Verification
Every result is due one clock after the cycle that caused it. data_o is registered, so the output for the data bit and keystream bit present before an edge appears just after that edge. A load or a pause takes effect in the state at the same edge. The bench drives inputs on the falling edge and samples data_o two nanoseconds after the following rising edge. It compares data_o with a bench model of the register that is advanced at that same edge. The state is observed through the ports by feeding zero data, which makes data_o the keystream itself.

// File: rtl/stream_cipher_pkg.sv
package stream_cipher_pkg;
  parameter int unsigned LFSR_W = 32;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } cipher_op_e;
endpackage

// File: rtl/cipher_ctrl.sv
module cipher_ctrl
  import stream_cipher_pkg::*;
(
  input  logic       en_i,
  input  logic       load_i,
  output cipher_op_e op_o
);
  // load wins over step
  always_comb begin
    if (load_i)    op_o = OP_LOAD;
    else if (en_i) op_o = OP_STEP;
    else           op_o = OP_IDLE;
  end

  always_comb begin
    a_op_r2: assert (!(load_i && op_o != OP_LOAD));
  end
endmodule

// File: rtl/galois_lfsr.sv
module galois_lfsr
  import stream_cipher_pkg::*;
#(
  parameter int unsigned W = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cipher_op_e   op_i,
  input  logic [W-1:0] taps_i,
  input  logic [W-1:0] seed_i,
  output logic         ks_o
);
  logic [W-1:0] state_q, taps_q, state_nx;
  logic         fb;

  assign fb   = state_q[0];
  assign ks_o = state_q[0];

  // shift toward lsb, taps folded in when the leaving bit is set
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign state_nx[i] = fb & taps_q[i];
    end else begin : g_mid
      assign state_nx[i] = state_q[i+1] ^ (fb & taps_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      taps_q  <= '0;
    end else begin
      case (op_i)
        OP_LOAD: begin
          state_q <= seed_i;
          taps_q  <= taps_i;
        end
        OP_STEP: state_q <= state_nx;
        default: ;
      endcase
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> state_q == $past(seed_i) && taps_q == $past(taps_i));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_IDLE |=> $stable(state_q) && $stable(taps_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_STEP && !state_q[0] |=> state_q == ($past(state_q) >> 1));
  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_STEP && state_q == '0 |=> state_q == '0);
endmodule

// File: rtl/stream_mixer.sv
module stream_mixer
  import stream_cipher_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cipher_op_e op_i,
  input  logic       ks_i,
  input  logic       data_i,
  output logic       data_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               out_q <= 1'b0;
    else if (op_i == OP_STEP)  out_q <= data_i ^ ks_i;
    else                       out_q <= 1'b0;
  end

  assign data_o = out_q;

  p_mix_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_STEP |=> data_o == ($past(data_i) ^ $past(ks_i)));
  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i != OP_STEP |=> !data_o);
endmodule

// File: rtl/stream_cipher_ch.sv
module stream_cipher_ch
  import stream_cipher_pkg::*;
#(
  parameter int unsigned W = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] taps_i,
  input  logic [W-1:0] seed_i,
  input  logic         data_i,
  output logic         data_o
);
  cipher_op_e op;
  logic       ks;

  cipher_ctrl u_ctrl (
    .en_i   (en_i),
    .load_i (load_i),
    .op_o   (op)
  );

  galois_lfsr #(.W(W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .taps_i (taps_i),
    .seed_i (seed_i),
    .ks_o   (ks)
  );

  stream_mixer u_mix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .ks_i   (ks),
    .data_i (data_i),
    .data_o (data_o)
  );

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !data_o);
endmodule

// File: tb/stream_cipher_ch_tb.sv
`timescale 1ns/1ps
module stream_cipher_ch_tb;
  localparam int W = 32;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, load = 1'b0, din = 1'b0;
  logic [W-1:0] taps = '0, seed = '0;
  logic dout;

  int checks = 0, errors = 0;
  logic [W-1:0] m_state = '0, m_taps = '0;
  logic exp_o;
  logic ct [0:63];

  always #4 clk = ~clk;

  stream_cipher_ch u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .load_i(load),
    .taps_i(taps), .seed_i(seed), .data_i(din), .data_o(dout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample 2 ns later
  task automatic cyc(input logic e, input logic l, input logic d);
    @(negedge clk);
    en = e; load = l; din = d;
    @(posedge clk);
    if (l) begin
      m_state = seed; m_taps = taps; exp_o = 1'b0;
    end else if (e) begin
      exp_o = d ^ m_state[0];
      m_state = (m_state >> 1) ^ (m_state[0] ? m_taps : '0);
    end else begin
      exp_o = 1'b0;
    end
    #2;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #20;
    chk("R1 reset out", dout, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    m_state = '0; m_taps = '0;
    cyc(1'b0, 1'b0, 1'b1);
    chk("R1 idle after reset", dout, 1'b0);
  endtask

  task automatic t_zero_state;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, i[0] ^ i[2]);
      chk("R6 zero state passthrough", dout, i[0] ^ i[2]);
    end
  endtask

  task automatic t_keystream(input logic [W-1:0] t, input logic [W-1:0] s, input int n);
    taps = t; seed = s;
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2 load out zero", dout, 1'b0);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk("R4 keystream", dout, exp_o);
    end
  endtask

  task automatic t_data;
    for (int i = 0; i < 40; i++) begin
      logic d;
      d = (i % 3 == 0) ^ (i > 20);
      cyc(1'b1, 1'b0, d);
      chk("R3 mix", dout, exp_o);
    end
  endtask

  task automatic t_pause;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0, 1'b1);
      chk("R5 disabled out", dout, 1'b0);
    end
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk("R5 resume keystream", dout, exp_o);
    end
  endtask

  task automatic t_load_prio;
    taps = 32'h8020_0003; seed = 32'h0000_0001;
    cyc(1'b1, 1'b1, 1'b1);
    chk("R2 load priority out", dout, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R2 seed lsb", dout, 1'b1);
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk("R2 post load keystream", dout, exp_o);
    end
  endtask

  task automatic t_roundtrip;
    taps = 32'hA300_0001; seed = 32'h5EED_C0DE;
    cyc(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, (i * 7 % 5) > 1);
      ct[i] = dout;
    end
    cyc(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, ct[i]);
      chk("R7 decrypt", dout, (i * 7 % 5) > 1);
    end
  endtask

  initial begin
    t_reset();
    t_zero_state();
    t_keystream(32'h8020_0003, 32'hDEAD_BEEF, 70);
    t_data();
    t_pause();
    t_keystream(32'h0000_0000, 32'h0000_00B5, 40);
    t_keystream(32'hFFFF_FFFF, 32'h8000_0001, 40);
    t_load_prio();
    t_roundtrip();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule